// File: doc/BRIEF.md
# FMA Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add unit that computes z + x*y. Each operand arrives as a 3-bit class code and its 32-bit encoding, and the block checks whether the result follows from the operand classes alone. If it does, the block returns a bypass result, with an invalid-operation flag where one applies. If it does not, it asks the arithmetic datapath to run and marks which operands are denormal and need normalization first.

A fixed precedence applies. A signaling NaN addend comes before everything else. Signaling and quiet NaNs in the product operands come next. The product cases (infinity times zero, infinite product, zero product, finite nonzero product) come last, and in these a quiet NaN addend takes over the infinite-product cases. All outputs are registered, so a result appears one clock after its operands are sampled.

Top module: `fma_special_resolver`

## Requirements
- R1: While the synchronous active-high reset is high, byp_valid, byp_result, invalid_op, need_datapath and all three normalization flags are zero on the following clock edge.
- R2: Class codes are 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN and 5 signaling NaN. The operand sign is bit 31 of the encoding. Outputs reflect the operands sampled at the previous rising edge, and byp_valid and need_datapath are never high together.
- R3: A signaling NaN addend gives byp_valid=1 and invalid_op=1, whatever x and y are. The result is z with fraction bit 22 set.
- R4: Otherwise, a signaling NaN x gives x with bit 22 set. A signaling NaN y with a non-signaling x gives y with bit 22 set. Both cases raise invalid_op.
- R5: Otherwise, a quiet NaN y with a non-NaN x returns y unchanged. A quiet NaN x returns x unchanged. Neither raises invalid_op.
- R6: Infinity times zero, in either order, returns z if z is a quiet NaN. Otherwise it raises invalid_op and returns 0x7FC00000.
- R7: Infinity times a nonzero finite value or infinity returns z if z is a quiet NaN. Otherwise it returns infinity whose sign is the XOR of the x and y signs (0x7F800000 or 0xFF800000).
- R8: A zero product (zero times zero, normal or denormal) returns infinity with z's sign if z is infinite. Otherwise it returns z unchanged.
- R9: A finite nonzero product returns z if z is a quiet NaN, or infinity with z's sign if z is infinite. Otherwise need_datapath=1, byp_valid=0 and byp_result=0.
- R10: Each normalization flag is high only when need_datapath is high and its operand is denormal. The flags are zero on every bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| z_cls | input | 3 | Addend class code |
| x_cls | input | 3 | First multiplicand class code |
| y_cls | input | 3 | Second multiplicand class code |
| z_word | input | 32 | Addend encoding |
| x_word | input | 32 | First multiplicand encoding |
| y_word | input | 32 | Second multiplicand encoding |
| byp_valid | output | 1 | Result resolved without arithmetic |
| byp_result | output | 32 | Bypass result encoding |
| invalid_op | output | 1 | Invalid-operation flag |
| need_datapath | output | 1 | Arithmetic datapath must compute the result |
| norm_z | output | 1 | Addend needs normalization |
| norm_x | output | 1 | First multiplicand needs normalization |
| norm_y | output | 1 | Second multiplicand needs normalization |

## Verification
The bench gives NaN operands in rival pairs: signaling against signaling, signaling against quiet, and quiet against quiet, with a quiet NaN addend in some of them. These cases show whether the addend and x really take precedence over y, and whether quieting changes only bit 22. The product cases use pairs that differ only in the addend class (normal, quiet NaN, infinite, denormal). These show where a quiet NaN addend wins, where an infinite addend wins, and where the request goes to the datapath. Denormals in each operand slot, on both bypass and datapath outcomes, check that the normalization flags follow the path taken and do not simply follow the class.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO  = 3'd0,
    CLS_NORM  = 3'd1,
    CLS_DNORM = 3'd2,
    CLS_INF   = 3'd3,
    CLS_QNAN  = 3'd4,
    CLS_SNAN  = 3'd5
  } fp_cls_e;

  typedef struct packed {
    logic zero;
    logic norm;
    logic dnorm;
    logic inf;
    logic qnan;
    logic snan;
  } cls_flags_t;
endpackage

// File: rtl/fsr_class_decode.sv
module fsr_class_decode
  import fsr_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic [CLS_W-1:0] cls,
  output cls_flags_t       flags
);
  always_comb begin
    flags       = '0;
    flags.zero  = (cls == CLS_W'(CLS_ZERO));
    flags.norm  = (cls == CLS_W'(CLS_NORM));
    flags.dnorm = (cls == CLS_W'(CLS_DNORM));
    flags.inf   = (cls == CLS_W'(CLS_INF));
    flags.qnan  = (cls == CLS_W'(CLS_QNAN));
    flags.snan  = (cls == CLS_W'(CLS_SNAN));
  end
endmodule

// File: rtl/fsr_nan_pick.sv
module fsr_nan_pick #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic              z_snan,
  input  logic              x_snan,
  input  logic              x_qnan,
  input  logic              y_snan,
  input  logic              y_qnan,
  input  logic [WORD_W-1:0] z_word,
  input  logic [WORD_W-1:0] x_word,
  input  logic [WORD_W-1:0] y_word,
  output logic              hit,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);

  always_comb begin
    hit     = 1'b1;
    invalid = 1'b0;
    result  = '0;
    if (z_snan) begin
      invalid = 1'b1;
      result  = z_word | QUIET_BIT;
    end else if (x_snan) begin
      invalid = 1'b1;
      result  = x_word | QUIET_BIT;
    end else if (y_snan) begin
      invalid = 1'b1;
      result  = y_word | QUIET_BIT;
    end else if (y_qnan && !x_qnan) begin
      result  = y_word;
    end else if (x_qnan) begin
      result  = x_word;
    end else begin
      hit     = 1'b0;
    end
  end
endmodule

// File: rtl/fsr_prod_pick.sv
module fsr_prod_pick #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic              x_zero,
  input  logic              x_norm,
  input  logic              x_dnorm,
  input  logic              x_inf,
  input  logic              y_zero,
  input  logic              y_norm,
  input  logic              y_dnorm,
  input  logic              y_inf,
  input  logic              z_zero,
  input  logic              z_norm,
  input  logic              z_dnorm,
  input  logic              z_inf,
  input  logic              z_qnan,
  input  logic              prod_sign,
  input  logic [WORD_W-1:0] z_word,
  output logic              hit,
  output logic [WORD_W-1:0] result,
  output logic              invalid,
  output logic              need_dp
);
  localparam int EXP_W = WORD_W - FRAC_W - 1;
  localparam logic [WORD_W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic x_fin_nz, y_fin_nz, z_finite;
  logic inf_by_zero, inf_prod, zero_prod, fin_prod;

  assign x_fin_nz    = x_norm | x_dnorm;
  assign y_fin_nz    = y_norm | y_dnorm;
  assign z_finite    = z_zero | z_norm | z_dnorm;
  assign inf_by_zero = (x_inf & y_zero) | (x_zero & y_inf);
  assign inf_prod    = (x_inf & (y_fin_nz | y_inf)) | (y_inf & x_fin_nz);
  assign zero_prod   = (x_zero & (y_zero | y_fin_nz)) | (y_zero & x_fin_nz);
  assign fin_prod    = x_fin_nz & y_fin_nz;

  always_comb begin
    hit     = 1'b0;
    result  = '0;
    invalid = 1'b0;
    need_dp = 1'b0;
    if (inf_by_zero) begin
      hit = 1'b1;
      if (z_qnan) begin
        result = z_word;
      end else begin
        invalid = 1'b1;
        result  = DFLT_NAN;
      end
    end else if (inf_prod) begin
      hit    = 1'b1;
      result = z_qnan ? z_word : {prod_sign, INF_MAG};
    end else if (zero_prod) begin
      hit    = 1'b1;
      result = z_inf ? {z_word[WORD_W-1], INF_MAG} : z_word;
    end else if (fin_prod) begin
      if (z_qnan) begin
        hit    = 1'b1;
        result = z_word;
      end else if (z_inf) begin
        hit    = 1'b1;
        result = {z_word[WORD_W-1], INF_MAG};
      end else begin
        need_dp = z_finite;
      end
    end
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fsr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23,
  parameter int CLS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CLS_W-1:0]  z_cls,
  input  logic [CLS_W-1:0]  x_cls,
  input  logic [CLS_W-1:0]  y_cls,
  input  logic [WORD_W-1:0] z_word,
  input  logic [WORD_W-1:0] x_word,
  input  logic [WORD_W-1:0] y_word,
  output logic              byp_valid,
  output logic [WORD_W-1:0] byp_result,
  output logic              invalid_op,
  output logic              need_datapath,
  output logic              norm_z,
  output logic              norm_x,
  output logic              norm_y
);
  localparam int N_OPND = 3;

  // operand slots: 0 = z, 1 = x, 2 = y
  logic [CLS_W-1:0] cls_in [N_OPND];
  cls_flags_t       fl     [N_OPND];

  assign cls_in[0] = z_cls;
  assign cls_in[1] = x_cls;
  assign cls_in[2] = y_cls;

  for (genvar i = 0; i < N_OPND; i++) begin : g_dec
    fsr_class_decode #(.CLS_W(CLS_W)) u_dec (
      .cls   (cls_in[i]),
      .flags (fl[i])
    );
  end

  logic              nan_hit, nan_inv;
  logic [WORD_W-1:0] nan_res;
  logic              prd_hit, prd_inv, prd_dp;
  logic [WORD_W-1:0] prd_res;

  fsr_nan_pick #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_nan (
    .z_snan (fl[0].snan),
    .x_snan (fl[1].snan),
    .x_qnan (fl[1].qnan),
    .y_snan (fl[2].snan),
    .y_qnan (fl[2].qnan),
    .z_word (z_word),
    .x_word (x_word),
    .y_word (y_word),
    .hit    (nan_hit),
    .result (nan_res),
    .invalid(nan_inv)
  );

  fsr_prod_pick #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_prd (
    .x_zero   (fl[1].zero),
    .x_norm   (fl[1].norm),
    .x_dnorm  (fl[1].dnorm),
    .x_inf    (fl[1].inf),
    .y_zero   (fl[2].zero),
    .y_norm   (fl[2].norm),
    .y_dnorm  (fl[2].dnorm),
    .y_inf    (fl[2].inf),
    .z_zero   (fl[0].zero),
    .z_norm   (fl[0].norm),
    .z_dnorm  (fl[0].dnorm),
    .z_inf    (fl[0].inf),
    .z_qnan   (fl[0].qnan),
    .prod_sign(x_word[WORD_W-1] ^ y_word[WORD_W-1]),
    .z_word   (z_word),
    .hit      (prd_hit),
    .result   (prd_res),
    .invalid  (prd_inv),
    .need_dp  (prd_dp)
  );

  logic              nx_valid, nx_inv, nx_dp;
  logic [WORD_W-1:0] nx_res;
  logic [N_OPND-1:0] nx_norm;

  always_comb begin
    nx_valid = nan_hit | prd_hit;
    nx_res   = nan_hit ? nan_res : prd_res;
    nx_inv   = nan_hit ? nan_inv : prd_inv;
    nx_dp    = !nan_hit & prd_dp;
    for (int i = 0; i < N_OPND; i++) begin
      nx_norm[i] = nx_dp & fl[i].dnorm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid     <= 1'b0;
      byp_result    <= '0;
      invalid_op    <= 1'b0;
      need_datapath <= 1'b0;
      norm_z        <= 1'b0;
      norm_x        <= 1'b0;
      norm_y        <= 1'b0;
    end else begin
      byp_valid     <= nx_valid;
      byp_result    <= nx_res;
      invalid_op    <= nx_inv;
      need_datapath <= nx_dp;
      norm_z        <= nx_norm[0];
      norm_x        <= nx_norm[1];
      norm_y        <= nx_norm[2];
    end
  end
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23,
  parameter int CLS_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CLS_W-1:0]  z_cls,
  input logic [CLS_W-1:0]  x_cls,
  input logic [WORD_W-1:0] z_word,
  input logic              byp_valid,
  input logic [WORD_W-1:0] byp_result,
  input logic              invalid_op,
  input logic              need_datapath,
  input logic              norm_z,
  input logic              norm_x,
  input logic              norm_y
);
  localparam logic [CLS_W-1:0]  SNAN_CODE = CLS_W'(5);
  localparam logic [WORD_W-1:0] QBIT      = WORD_W'(1) << (FRAC_W - 1);

  a_r2_one_path: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byp_valid, need_datapath}));

  a_r3_addend_snan: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(z_cls) == SNAN_CODE) |->
      (byp_valid && invalid_op && byp_result == ($past(z_word) | QBIT)));

  a_r4_x_snan_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x_cls) == SNAN_CODE) |->
      (byp_valid && invalid_op && byp_result[FRAC_W-1]));

  a_r6_invalid_bypass: assert property (@(posedge clk) disable iff (rst)
    invalid_op |-> byp_valid);

  a_r10_norm_on_dp: assert property (@(posedge clk) disable iff (rst)
    (norm_z || norm_x || norm_y) |-> need_datapath);
endmodule

bind fma_special_resolver fsr_chk #(
  .WORD_W(WORD_W), .FRAC_W(FRAC_W), .CLS_W(CLS_W)
) u_fsr_chk (
  .clk          (clk),
  .rst          (rst),
  .z_cls        (z_cls),
  .x_cls        (x_cls),
  .z_word       (z_word),
  .byp_valid    (byp_valid),
  .byp_result   (byp_result),
  .invalid_op   (invalid_op),
  .need_datapath(need_datapath),
  .norm_z       (norm_z),
  .norm_x       (norm_x),
  .norm_y       (norm_y)
);

// File: tb/tb_fma_special_resolver.sv
`timescale 1ns/1ps
module tb_fma_special_resolver;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  z_cls = '0, x_cls = '0, y_cls = '0;
  logic [31:0] z_word = '0, x_word = '0, y_word = '0;
  logic        byp_valid, invalid_op, need_datapath, norm_z, norm_x, norm_y;
  logic [31:0] byp_result;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fma_special_resolver dut (
    .clk(clk), .rst(rst),
    .z_cls(z_cls), .x_cls(x_cls), .y_cls(y_cls),
    .z_word(z_word), .x_word(x_word), .y_word(y_word),
    .byp_valid(byp_valid), .byp_result(byp_result), .invalid_op(invalid_op),
    .need_datapath(need_datapath), .norm_z(norm_z), .norm_x(norm_x), .norm_y(norm_y)
  );

  // {zc, xc, yc, z, x, y, valid, result, invalid, datapath, norm{z,x,y}}
  localparam logic [142:0] VEC [NV] = '{
    {3'd5,3'd5,3'd4, 32'h7F802222, 32'hFF800044, 32'h7FC00055, 1'b1, 32'h7FC02222, 1'b1,1'b0,3'b000}, // R3
    {3'd1,3'd5,3'd5, 32'h40000000, 32'hFF800044, 32'h7F800066, 1'b1, 32'hFFC00044, 1'b1,1'b0,3'b000}, // R4
    {3'd4,3'd1,3'd5, 32'h7FC01111, 32'h3F800000, 32'h7F800066, 1'b1, 32'h7FC00066, 1'b1,1'b0,3'b000}, // R4
    {3'd4,3'd3,3'd4, 32'h7FC01111, 32'h7F800000, 32'h7FC00055, 1'b1, 32'h7FC00055, 1'b0,1'b0,3'b000}, // R5
    {3'd1,3'd4,3'd0, 32'h40000000, 32'hFFC00033, 32'h00000000, 1'b1, 32'hFFC00033, 1'b0,1'b0,3'b000}, // R5
    {3'd1,3'd4,3'd4, 32'h40000000, 32'hFFC00033, 32'h7FC00055, 1'b1, 32'hFFC00033, 1'b0,1'b0,3'b000}, // R5
    {3'd1,3'd3,3'd0, 32'h40000000, 32'h7F800000, 32'h00000000, 1'b1, 32'h7FC00000, 1'b1,1'b0,3'b000}, // R6
    {3'd4,3'd0,3'd3, 32'h7FC01111, 32'h80000000, 32'hFF800000, 1'b1, 32'h7FC01111, 1'b0,1'b0,3'b000}, // R6
    {3'd1,3'd3,3'd1, 32'h40000000, 32'hFF800000, 32'h3F800000, 1'b1, 32'hFF800000, 1'b0,1'b0,3'b000}, // R7
    {3'd0,3'd3,3'd3, 32'h00000000, 32'hFF800000, 32'hFF800000, 1'b1, 32'h7F800000, 1'b0,1'b0,3'b000}, // R7
    {3'd4,3'd2,3'd3, 32'h7FC01111, 32'h00000001, 32'h7F800000, 1'b1, 32'h7FC01111, 1'b0,1'b0,3'b000}, // R7
    {3'd3,3'd0,3'd1, 32'hFF800000, 32'h00000000, 32'h3F800000, 1'b1, 32'hFF800000, 1'b0,1'b0,3'b000}, // R8
    {3'd1,3'd2,3'd0, 32'h40000000, 32'h00000001, 32'h80000000, 1'b1, 32'h40000000, 1'b0,1'b0,3'b000}, // R8
    {3'd2,3'd0,3'd0, 32'h00000001, 32'h00000000, 32'h00000000, 1'b1, 32'h00000001, 1'b0,1'b0,3'b000}, // R8
    {3'd4,3'd1,3'd1, 32'h7FC01111, 32'h3F800000, 32'hBF800000, 1'b1, 32'h7FC01111, 1'b0,1'b0,3'b000}, // R9
    {3'd3,3'd2,3'd1, 32'h7F800000, 32'h00000001, 32'h3F800000, 1'b1, 32'h7F800000, 1'b0,1'b0,3'b000}, // R9
    {3'd1,3'd1,3'd1, 32'h40000000, 32'h3F800000, 32'hBF800000, 1'b0, 32'h00000000, 1'b0,1'b1,3'b000}, // R9
    {3'd2,3'd2,3'd1, 32'h00000001, 32'h00000001, 32'h3F800000, 1'b0, 32'h00000000, 1'b0,1'b1,3'b110}, // R10
    {3'd1,3'd1,3'd2, 32'h40000000, 32'h3F800000, 32'h00000001, 1'b0, 32'h00000000, 1'b0,1'b1,3'b001}, // R10
    {3'd2,3'd1,3'd0, 32'h00000001, 32'h3F800000, 32'h00000000, 1'b1, 32'h00000001, 1'b0,1'b0,3'b000}  // R10
  };
  localparam int VREQ [NV] = '{3,4,4,5,5,5,6,6,7,7,7,8,8,8,9,9,9,10,10,10};

  function automatic logic [37:0] outs();
    return {byp_valid, byp_result, invalid_op, need_datapath, norm_z, norm_x, norm_y};
  endfunction

  task automatic check(input string req, input logic [37:0] act, input logic [37:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [142:0] v);
    {z_cls, x_cls, y_cls, z_word, x_word, y_word} = v[142:38];
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), 38'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VREQ[i], i), outs(), VEC[i][37:0]);
      check("R2 one path", {37'd0, byp_valid & need_datapath}, 38'd0);
    end

    // R2: new operands do not show before the next rising edge
    apply(VEC[6]);
    #1;
    check("R2 hold before edge", outs(), VEC[NV-1][37:0]);
    @(negedge clk);
    check("R2 after edge", outs(), VEC[6][37:0]);

    // R1: reset wins over a signaling NaN addend
    apply(VEC[0]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", outs(), 38'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 after reset", outs(), VEC[0][37:0]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule